// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Generator

This block drives the three external bus strobes of a small processor core. The sync strobe marks the first state of each machine cycle. The read-enable strobe (`dbin`) tells memory or a peripheral to put data on the bus. The active-low write strobe (`wr_n`) times an outgoing data transfer. The block takes the current state from the state sequencer, a pair of single-cycle phase enables that mark the phase-1 and phase-2 edges inside each state, and a 4-bit machine-cycle type from the instruction decoder. Every strobe edge falls on a chosen phase edge of a chosen state. Wait states inserted between the second and third states lengthen the read and write windows.

The design runs on one fast clock. The sequencer holds `tstate` for the whole of a state and pulses `ph1_en`, then later `ph2_en`, once per state. A strobe changes only on a clock edge where the matching enable is high. The exception is the halt and hold states: there the strobes drop on the very next clock edge. The cycle type is captured when the phase-1 edge of the first state arrives, so the decoder is free to change its output afterwards. No data flows through this block, so it has no valid/ready handshake. All of its pins are plain control signals.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `sync` is 0, `dbin` is 0 and `wr_n` is 1.
- R2: `sync` goes high on a phase-1 edge taken in state T1. It goes low on the next phase-1 edge taken in any other state, so it stays high for exactly one state period.
- R3: The cycle type is sampled only on the phase-1 edge of T1, with the codes fetch=0, memory read=1, memory write=2, stack read=3, stack write=4, input=5, output=6, interrupt acknowledge=7, halt=8, halt-with-interrupt=9. A change on `mc_type` after that edge has no effect on the strobes until the next T1.
- R4: `dbin` is asserted only in cycles of type 0, 1, 3 or 7.
- R5: `dbin` rises on the phase-2 edge of T2 and falls on the phase-2 edge of T3.
- R6: Each TW state between T2 and T3 keeps `dbin` high for one more state period. The high time is (1 + waits) state periods.
- R7: `wr_n` is driven low only in cycles of type 2, 4 or 6.
- R8: `wr_n` falls on the first phase-1 edge after T2. It returns high on the phase-1 edge of the state that follows T3.
- R9: Each TW state between T2 and T3 keeps `wr_n` low for one more state period. The low time is (1 + waits) state periods.
- R10: While `tstate` is halt (6) or hold (7), all strobes are forced inactive on the next clock edge, whatever the phase enables and the cycle in progress.
- R11: Types 5, 8 and 9, and the unused codes 10 to 15, assert neither `dbin` nor `wr_n`.
- R12: State codes are T1=0, T2=1, T3=2, T4=3, T5=4, TW=5, halt=6, hold=7. Apart from reset and R10, `sync` and `wr_n` change only on edges with `ph1_en` high, and `dbin` changes only on edges with `ph2_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1_en | input | 1 | One-cycle pulse marking the phase-1 edge of the current state |
| ph2_en | input | 1 | One-cycle pulse marking the phase-2 edge of the current state |
| tstate | input | 3 | Current sequencer state code (R12) |
| mc_type | input | 4 | Machine-cycle type from the decoder (R3) |
| sync | output | 1 | First-state marker of each machine cycle |
| dbin | output | 1 | Read data enable, active high |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The three outputs are registered. A wrong captured cycle type or a wrong strobe register shows up at the ports on the next qualifying phase edge, which is at most one state period later. A latched type that is wrongly updated mid-cycle would turn a read window into a write window, or drop it entirely. An off-by-one in the state match would shift a strobe edge by a whole state, so the measured high or low lengths drift by four clocks per cycle. The bench compares every output on every clock against a behavioural model, and it also measures the length of each strobe window against the wait count.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  localparam int ST_W = 3;
  localparam int CT_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_T1   = 3'd0,
    ST_T2   = 3'd1,
    ST_T3   = 3'd2,
    ST_T4   = 3'd3,
    ST_T5   = 3'd4,
    ST_TW   = 3'd5,
    ST_HALT = 3'd6,
    ST_HOLD = 3'd7
  } tstate_e;

  localparam logic [CT_W-1:0] MC_FETCH = 4'd0;
  localparam logic [CT_W-1:0] MC_MRD   = 4'd1;
  localparam logic [CT_W-1:0] MC_MWR   = 4'd2;
  localparam logic [CT_W-1:0] MC_SRD   = 4'd3;
  localparam logic [CT_W-1:0] MC_SWR   = 4'd4;
  localparam logic [CT_W-1:0] MC_IN    = 4'd5;
  localparam logic [CT_W-1:0] MC_OUT   = 4'd6;
  localparam logic [CT_W-1:0] MC_INTA  = 4'd7;
  localparam logic [CT_W-1:0] MC_HALT  = 4'd8;
  localparam logic [CT_W-1:0] MC_HALTI = 4'd9;

  function automatic logic mc_reads(input logic [CT_W-1:0] c);
    case (c)
      MC_FETCH, MC_MRD, MC_SRD, MC_INTA: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic mc_writes(input logic [CT_W-1:0] c);
    case (c)
      MC_MWR, MC_SWR, MC_OUT: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic logic st_parked(input tstate_e s);
    return (s == ST_HALT) || (s == ST_HOLD);
  endfunction
endpackage

// File: rtl/bsg_cycle_latch.sv
module bsg_cycle_latch
  import bsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph1_en,
  input  tstate_e         tstate,
  input  logic [CT_W-1:0] mc_type,
  output logic            rd_cyc,
  output logic            wr_cyc
);
  logic capture;
  assign capture = ph1_en && (tstate == ST_T1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cyc <= 1'b0;
      wr_cyc <= 1'b0;
    end else if (capture) begin
      rd_cyc <= mc_reads(mc_type);
      wr_cyc <= mc_writes(mc_type);
    end
  end

  // R3: the class of the cycle is fixed between T1 phase-1 captures
  a_r3_class_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(rd_cyc) && $stable(wr_cyc)));
endmodule

// File: rtl/bsg_sync_gen.sv
module bsg_sync_gen
  import bsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph1_en,
  input  tstate_e tstate,
  output logic    sync
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sync <= 1'b0;
    else if (st_parked(tstate)) sync <= 1'b0;
    else if (ph1_en)           sync <= (tstate == ST_T1);
  end

  a_r2_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> ($past(ph1_en) && $past(tstate) == ST_T1));

  a_r12_sync_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync) |-> ($past(ph1_en) || st_parked($past(tstate))));
endmodule

// File: rtl/bsg_read_gen.sv
module bsg_read_gen
  import bsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph2_en,
  input  tstate_e tstate,
  input  logic    rd_cyc,
  output logic    dbin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dbin <= 1'b0;
    else if (st_parked(tstate)) dbin <= 1'b0;
    else if (ph2_en) begin
      if (tstate == ST_T2 && rd_cyc) dbin <= 1'b1;
      else if (tstate == ST_T3)       dbin <= 1'b0;
    end
  end

  a_r5_dbin_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbin) |-> ($past(ph2_en) && $past(tstate) == ST_T2));

  a_r4_dbin_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbin) |-> $past(rd_cyc));

  a_r5_dbin_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbin) |-> (($past(ph2_en) && $past(tstate) == ST_T3) ||
                     st_parked($past(tstate))));

  // R6: a wait state never ends the read window
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dbin && tstate == ST_TW) |=> dbin);
endmodule

// File: rtl/bsg_write_gen.sv
module bsg_write_gen
  import bsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ph1_en,
  input  tstate_e tstate,
  input  logic    wr_cyc,
  output logic    wr_n
);
  logic in_window;
  assign in_window = (tstate == ST_TW) || (tstate == ST_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wr_n <= 1'b1;
    else if (st_parked(tstate)) wr_n <= 1'b1;
    else if (ph1_en)            wr_n <= !(wr_cyc && in_window);
  end

  a_r8_wr_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(ph1_en) &&
                     ($past(tstate) == ST_TW || $past(tstate) == ST_T3)));

  a_r7_wr_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(wr_cyc));

  a_r12_wr_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_n) |-> ($past(ph1_en) || st_parked($past(tstate))));
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int STATE_W = ST_W,
  parameter int TYPE_W  = CT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ph1_en,
  input  logic               ph2_en,
  input  logic [STATE_W-1:0] tstate,
  input  logic [TYPE_W-1:0]  mc_type,
  output logic               sync,
  output logic               dbin,
  output logic               wr_n
);
  tstate_e st;
  logic    rd_cyc;
  logic    wr_cyc;

  assign st = tstate_e'(tstate[ST_W-1:0]);

  bsg_cycle_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph1_en  (ph1_en),
    .tstate  (st),
    .mc_type (mc_type[CT_W-1:0]),
    .rd_cyc  (rd_cyc),
    .wr_cyc  (wr_cyc)
  );

  bsg_sync_gen u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph1_en (ph1_en),
    .tstate (st),
    .sync   (sync)
  );

  bsg_read_gen u_read (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph2_en (ph2_en),
    .tstate (st),
    .rd_cyc (rd_cyc),
    .dbin   (dbin)
  );

  bsg_write_gen u_write (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph1_en (ph1_en),
    .tstate (st),
    .wr_cyc (wr_cyc),
    .wr_n   (wr_n)
  );

  a_r10_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st_parked(st) |=> (!sync && !dbin && wr_n));

  // R4 and R7: a cycle never both reads and writes
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbin && !wr_n));

  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (!sync && !dbin && wr_n || $time == 0);
  end
endmodule

// File: tb/sim_bus_strobe_gen.sv
module sim_bus_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph1_en = 1'b0;
  logic       ph2_en = 1'b0;
  logic [2:0] tstate = 3'd3;
  logic [3:0] mc_type = 4'd0;
  logic       sync, dbin, wr_n;

  always #10 clk = ~clk;

  bus_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .tstate(tstate), .mc_type(mc_type),
    .sync(sync), .dbin(dbin), .wr_n(wr_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    counting = 1'b0;
  int    cnt_s, cnt_d, cnt_w;
  string tag_s = "R2,R12";
  string tag_d = "R5";
  string tag_w = "R8";

  // behavioural reference
  bit m_sync = 1'b0, m_dbin = 1'b0, m_wrn = 1'b1;
  int m_type = 15;

  function automatic bit rd_kind(input int c);
    return (c == 0) || (c == 1) || (c == 3) || (c == 7);
  endfunction
  function automatic bit wr_kind(input int c);
    return (c == 2) || (c == 4) || (c == 6);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_dbin = 0; m_wrn = 1; m_type = 15;
    end else if (tstate == 3'd6 || tstate == 3'd7) begin
      m_sync = 0; m_dbin = 0; m_wrn = 1;
    end else begin
      if (ph1_en) begin
        m_wrn = !(wr_kind(m_type) && (tstate == 3'd5 || tstate == 3'd2));
        if (tstate == 3'd0) begin
          m_type = int'(mc_type);
          m_sync = 1;
        end else m_sync = 0;
      end
      if (ph2_en) begin
        if (tstate == 3'd1 && rd_kind(m_type)) m_dbin = 1;
        else if (tstate == 3'd2) m_dbin = 0;
      end
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_s, "sync", int'(sync), int'(m_sync));
      chk(tag_d, "dbin", int'(dbin), int'(m_dbin));
      chk(tag_w, "wr_n", int'(wr_n), int'(m_wrn));
      if (counting) begin
        cnt_s += int'(sync);
        cnt_d += int'(dbin);
        cnt_w += int'(!wr_n);
      end
    end
  end

  // one state period: four clocks, phase-1 on the first, phase-2 on the third
  task automatic slot(input int st);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tstate = st[2:0];
      ph1_en = (k == 0);
      ph2_en = (k == 2);
      if (st == 0 && k == 1) mc_type = ~mc_type; // R3: late type change
    end
  endtask

  task automatic run_cyc(input int ty, input int nw, input int ns, input bit tail);
    bit quiet;
    quiet = (ty == 5) || (ty > 7);
    tag_s = "R2,R12";
    tag_d = rd_kind(ty) ? ((nw > 0) ? "R3,R6" : "R3,R5") : (quiet ? "R11" : "R4");
    tag_w = wr_kind(ty) ? ((nw > 0) ? "R3,R9" : "R3,R8") : (quiet ? "R11" : "R7");
    mc_type = ty[3:0];
    cnt_s = 0; cnt_d = 0; cnt_w = 0;
    counting = 1'b1;
    slot(0);
    slot(1);
    repeat (nw) slot(5);
    slot(2);
    if (ns > 3) slot(3);
    if (ns > 4) slot(4);
    if (tail) begin
      tag_s = "R10"; tag_d = "R10"; tag_w = "R10";
      slot(7);
      counting = 1'b0;
      chk("R2", "sync_len", cnt_s, 4);
      chk(rd_kind(ty) ? "R6" : (quiet ? "R11" : "R4"), "dbin_len", cnt_d,
          rd_kind(ty) ? 4 * (nw + 1) : 0);
      chk(wr_kind(ty) ? "R9" : (quiet ? "R11" : "R7"), "wr_len", cnt_w,
          wr_kind(ty) ? 4 * (nw + 1) : 0);
    end else counting = 1'b0;
  endtask

  initial begin : main
    int waits[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    chk("R1", "sync_rst", int'(sync), 0);
    chk("R1", "dbin_rst", int'(dbin), 0);
    chk("R1", "wr_n_rst", int'(wr_n), 1);
    @(negedge clk) rst_n = 1'b1;

    for (int ty = 0; ty < 16; ty++)
      for (int w = 0; w < 3; w++)
        run_cyc(ty, waits[w], 3 + (ty + w) % 3, 1'b1);

    // back to back: write strobe must rise at the next state's phase-1 (R8)
    for (int ty = 0; ty < 10; ty++) run_cyc(ty, 1, 3 + ty % 3, 1'b0);
    tag_s = "R10"; tag_d = "R10"; tag_w = "R10";
    slot(7);

    // hold in the middle of a read window (R10)
    mc_type = 4'd0;
    slot(0); slot(1);
    chk("R5", "dbin_mid", int'(dbin), 1);
    tag_d = "R10";
    slot(7);
    chk("R10", "dbin_hold", int'(dbin), 0);

    // halt in the middle of a write window (R10)
    mc_type = 4'd2;
    tag_w = "R9";
    slot(0); slot(1); slot(5);
    chk("R9", "wr_mid", int'(wr_n), 0);
    tag_w = "R10";
    slot(6);
    chk("R10", "wr_halt", int'(wr_n), 1);
    chk("R10", "sync_halt", int'(sync), 0);
    slot(7);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule